// File: doc/BRIEF.md
# Sized Integer ALU with Condition Flags

This block is a datapath slice: eight general data registers and a five-bit condition code register. Each command selects a source and a destination register, an operation (add, subtract, AND, OR, XOR or move) and an operand size of byte, word or longword. The operation is applied to the low-order bits of the chosen size. Only those low bits of the destination are replaced, and the flags are derived from the sized result. When the immediate select is set, an immediate input replaces the source register. This lets a controller load constants without a separate path.

Commands are plain control pins. A command is presented together with `op_we` for one cycle and is always taken, so the block never applies back-pressure. Each accepted command produces a one-cycle `res_vld` pulse on the following cycle. The pulse carries the destination index and the full 32-bit value the destination now holds. `ccr` always shows the current flags. A command with an illegal size or opcode is dropped: nothing is written and no result is produced.

Top module: `sized_alu_top`

## Requirements
- R1: A synchronous reset clears all eight registers, the flags and `res_vld`.
- R2: The size code is 00 = byte (8 bits), 01 = word (16 bits), 10 = longword (32 bits). Size 11 writes no register, leaves the flags unchanged and gives no `res_vld`.
- R3: The opcode is 000 = add, 001 = subtract, 010 = AND, 011 = OR, 100 = XOR, 101 = move. Opcodes 110 and 111 write nothing and give no `res_vld`.
- R4: Add writes destination + source at the selected size.
- R5: Subtract writes destination − source at the selected size.
- R6: AND, OR and XOR combine destination with source. Move copies source into the destination.
- R7: Byte and word operations keep destination bits above bit 7 or bit 15 unchanged.
- R8: C (ccr bit 0) is the carry out of the sized MSB for add, and the borrow out of it for subtract.
- R9: V (ccr bit 1) is set on signed overflow of the sized add or subtract.
- R10: Z (ccr bit 2) is set when the sized result is zero. N (ccr bit 3) is the sized result's top bit.
- R11: For add and subtract, X (ccr bit 4) is set equal to C. Logical operations and move clear V and C and leave X unchanged.
- R12: State changes only at a clock edge with `op_we` high. `res_vld`, `res_dst` and `res_data` show the written value one cycle after the command.
- R13: With `op_use_imm` high, `op_imm` is the source operand. Otherwise the source is register `op_src`, which may equal `op_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_we | input | 1 | Command strobe / write enable |
| op_code | input | 3 | Operation select |
| op_size | input | 2 | Operand size code |
| op_src | input | 3 | Source register index |
| op_dst | input | 3 | Destination register index |
| op_use_imm | input | 1 | Use immediate as source |
| op_imm | input | 32 | Immediate operand |
| res_vld | output | 1 | Result pulse for an accepted command |
| res_dst | output | 3 | Destination index of the result |
| res_data | output | 32 | Full destination value after the write |
| ccr | output | 5 | Flags {X,N,Z,V,C} |

## Verification
Directed sums are placed at each size boundary: 0xFF+1 in a byte, 0x7FFF+1 in a word, and 0−1 in a longword. These separate a carry or borrow taken at the sized MSB from one taken at bit 31, and signed overflow from unsigned carry. Narrow operations on registers that hold nonzero upper bits show whether the upper bits survive. Logical operations issued after a carry show whether X is kept while V and C are cleared. Illegal size and opcode codes, commands held without the strobe, and a long pseudo-random mix with self-referencing and immediate sources confirm that nothing else alters the registers.

// File: rtl/sized_alu_pkg.sv
package sized_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_MOVE = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } alu_size_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  localparam int unsigned CCR_W = 5;

  function automatic logic op_is_arith(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic cmd_legal(input logic [2:0] op, input logic [1:0] sz);
    return (sz != SZ_BAD) && (op <= OP_MOVE);
  endfunction
endpackage

// File: rtl/sa_regfile.sv
module sa_regfile #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 32,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        regs[g] <= wr_data;
      end
    end
  end

  assign rd_a_data = regs[rd_a_idx];
  assign rd_b_data = regs[rd_b_idx];
endmodule

// File: rtl/sa_size_mask.sv
module sa_size_mask #(
  parameter int unsigned DW = 32,
  localparam int unsigned LW = $clog2(DW + 1)
) (
  input  logic [1:0]    size,
  output logic [DW-1:0] mask,
  output logic [LW-1:0] width
);
  import sized_alu_pkg::*;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        mask  = {{(DW-8){1'b0}}, 8'hFF};
        width = LW'(8);
      end
      SZ_WORD: begin
        mask  = {{(DW-16){1'b0}}, 16'hFFFF};
        width = LW'(16);
      end
      default: begin
        mask  = '1;
        width = LW'(DW);
      end
    endcase
  end
endmodule

// File: rtl/sa_core.sv
module sa_core #(
  parameter int unsigned DW = 32,
  localparam int unsigned LW = $clog2(DW + 1)
) (
  input  logic [2:0]    op,
  input  logic [1:0]    size,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  input  sized_alu_pkg::ccr_t ccr_in,
  output logic [DW-1:0] merged,
  output sized_alu_pkg::ccr_t ccr_out
);
  import sized_alu_pkg::*;

  logic [DW-1:0] mask;
  logic [LW-1:0] width;
  logic [LW-1:0] msb;
  logic [DW-1:0] am, bm, res;
  logic [DW:0]   sum_w, dif_w;
  logic          sa, sb, sr, cy, ov;

  sa_size_mask #(.DW(DW)) u_mask (
    .size  (size),
    .mask  (mask),
    .width (width)
  );

  assign msb   = width - LW'(1);
  assign am    = src & mask;
  assign bm    = dst & mask;
  assign sum_w = {1'b0, bm} + {1'b0, am};
  assign dif_w = {1'b0, bm} - {1'b0, am};

  always_comb begin
    unique case (op)
      OP_ADD:  res = sum_w[DW-1:0];
      OP_SUB:  res = dif_w[DW-1:0];
      OP_AND:  res = am & bm;
      OP_OR:   res = am | bm;
      OP_XOR:  res = am ^ bm;
      default: res = am;
    endcase
    res = res & mask;
  end

  assign sa = am[msb];
  assign sb = bm[msb];
  assign sr = res[msb];

  always_comb begin
    cy = 1'b0;
    ov = 1'b0;
    if (op == OP_ADD) begin
      cy = sum_w[width];
      ov = (sa == sb) && (sr != sa);
    end else if (op == OP_SUB) begin
      cy = dif_w[width];
      ov = (sa != sb) && (sr != sb);
    end
  end

  assign merged    = (dst & ~mask) | res;
  assign ccr_out.c = cy;
  assign ccr_out.v = ov;
  assign ccr_out.z = (res == '0);
  assign ccr_out.n = sr;
  assign ccr_out.x = op_is_arith(op) ? cy : ccr_in.x;
endmodule

// File: rtl/sized_alu_top.sv
module sized_alu_top #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 32,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_we,
  input  logic [2:0]    op_code,
  input  logic [1:0]    op_size,
  input  logic [IW-1:0] op_src,
  input  logic [IW-1:0] op_dst,
  input  logic          op_use_imm,
  input  logic [DW-1:0] op_imm,
  output logic          res_vld,
  output logic [IW-1:0] res_dst,
  output logic [DW-1:0] res_data,
  output logic [4:0]    ccr
);
  import sized_alu_pkg::*;

  logic [DW-1:0] src_rd, dst_rd, src_op, merged;
  logic          accept;
  ccr_t          ccr_q, ccr_nxt;

  assign accept = op_we && cmd_legal(op_code, op_size);
  assign src_op = op_use_imm ? op_imm : src_rd;

  sa_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (accept),
    .wr_idx    (op_dst),
    .wr_data   (merged),
    .rd_a_idx  (op_src),
    .rd_a_data (src_rd),
    .rd_b_idx  (op_dst),
    .rd_b_data (dst_rd)
  );

  sa_core #(.DW(DW)) u_core (
    .op      (op_code),
    .size    (op_size),
    .src     (src_op),
    .dst     (dst_rd),
    .ccr_in  (ccr_q),
    .merged  (merged),
    .ccr_out (ccr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ccr_q    <= '0;
      res_vld  <= 1'b0;
      res_dst  <= '0;
      res_data <= '0;
    end else begin
      res_vld <= accept;
      if (accept) begin
        ccr_q    <= ccr_nxt;
        res_dst  <= op_dst;
        res_data <= merged;
      end
    end
  end

  assign ccr = ccr_q;
endmodule

// File: rtl/sized_alu_chk.sv
module sized_alu_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          op_we,
  input logic [2:0]    op_code,
  input logic [1:0]    op_size,
  input logic          res_vld,
  input logic [DW-1:0] res_data,
  input logic [4:0]    ccr,
  input logic [DW-1:0] dst_rd
);
  logic [DW-1:0] sized_res;
  logic [1:0]    size_d;

  always_ff @(posedge clk) size_d <= op_size;

  always_comb begin
    case (size_d)
      2'd0:    sized_res = res_data & {{(DW-8){1'b0}}, 8'hFF};
      2'd1:    sized_res = res_data & {{(DW-16){1'b0}}, 16'hFFFF};
      default: sized_res = res_data;
    endcase
  end

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ccr == 5'd0) && !res_vld); // R1

  AST_BAD_SIZE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (op_we && op_size == 2'b11) |=> !res_vld && $stable(ccr)); // R2

  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (op_we && op_code > 3'd5) |=> !res_vld && $stable(ccr)); // R3

  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_we && op_size != 2'b11 && op_code >= 3'd2 && op_code <= 3'd5)
    |=> (ccr[1:0] == 2'b00) && (ccr[4] == $past(ccr[4]))); // R11

  AST_X_TRACKS_C: assert property (@(posedge clk) disable iff (rst)
    (op_we && op_size != 2'b11 && op_code <= 3'd1) |=> (ccr[4] == ccr[0])); // R11

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (ccr[2] == (sized_res == '0))); // R10

  AST_UPPER_BYTE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (res_vld && size_d == 2'd0) |-> res_data[DW-1:8] == $past(dst_rd[DW-1:8])); // R7

  AST_UPPER_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (res_vld && size_d == 2'd1) |-> res_data[DW-1:16] == $past(dst_rd[DW-1:16])); // R7

  AST_VLD_NEEDS_WE: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(op_we)); // R12
endmodule

bind sized_alu_top sized_alu_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_we    (op_we),
  .op_code  (op_code),
  .op_size  (op_size),
  .res_vld  (res_vld),
  .res_data (res_data),
  .ccr      (ccr),
  .dst_rd   (dst_rd)
);

// File: tb/sized_alu_top_tb.sv
module sized_alu_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_we = 1'b0;
  logic [2:0]  op_code = '0;
  logic [1:0]  op_size = '0;
  logic [2:0]  op_src = '0;
  logic [2:0]  op_dst = '0;
  logic        op_use_imm = 1'b0;
  logic [31:0] op_imm = '0;
  logic        res_vld;
  logic [2:0]  res_dst;
  logic [31:0] res_data;
  logic [4:0]  ccr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [2:0]  dst;
    logic [31:0] data;
    logic [4:0]  flags;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] m_reg [8];
  logic [4:0]  m_ccr;

  always #2 clk = ~clk;

  sized_alu_top u_dut (
    .clk(clk), .rst(rst), .op_we(op_we), .op_code(op_code), .op_size(op_size),
    .op_src(op_src), .op_dst(op_dst), .op_use_imm(op_use_imm), .op_imm(op_imm),
    .res_vld(res_vld), .res_dst(res_dst), .res_data(res_data), .ccr(ccr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [1:0] sz,
                                input logic [31:0] a, input logic [31:0] b, input logic [4:0] cin,
                                output logic [31:0] nd, output logic [4:0] cout);
    int n;
    longint unsigned m, av, bv, r;
    logic c, v, x;
    n  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m  = (64'd1 << n) - 1;
    av = {32'd0, a} & m;
    bv = {32'd0, b} & m;
    c = 1'b0; v = 1'b0; x = cin[4];
    case (op)
      3'd0: begin
        r = bv + av;
        c = r[n];
        r = r & m;
        v = (av[n-1] == bv[n-1]) && (r[n-1] != av[n-1]);
        x = c;
      end
      3'd1: begin
        c = bv < av;
        r = (bv - av) & m;
        v = (av[n-1] != bv[n-1]) && (r[n-1] != bv[n-1]);
        x = c;
      end
      3'd2: r = av & bv;
      3'd3: r = av | bv;
      3'd4: r = av ^ bv;
      default: r = av;
    endcase
    nd   = (b & ~m[31:0]) | r[31:0];
    cout = {x, r[n-1], (r == 0), v, c};
  endfunction

  task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic [2:0] s,
                       input logic [2:0] d, input logic ui, input logic [31:0] im, input string tag);
    logic [31:0] nd;
    logic [4:0]  nc;
    exp_t        e;
    @(negedge clk);
    op_we = 1'b1; op_code = op; op_size = sz; op_src = s; op_dst = d;
    op_use_imm = ui; op_imm = im;
    if (sz != 2'b11 && op <= 3'd5) begin
      model(op, sz, ui ? im : m_reg[s], m_reg[d], m_ccr, nd, nc);
      m_reg[d] = nd;
      m_ccr    = nc;
      e.dst = d; e.data = nd; e.flags = nc; e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic idle(input int cyc);
    @(negedge clk);
    op_we = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic reject(input logic [2:0] op, input logic [1:0] sz, input logic [2:0] d, input string tag);
    issue(op, sz, 3'd1, d, 1'b1, 32'hDEAD_BEEF, tag);
    @(negedge clk);
    op_we = 1'b0;
    check(!res_vld, {tag, " no result"}, 64'(res_vld), 64'd0);
    check(ccr == m_ccr, {tag, " flags kept"}, 64'(ccr), 64'(m_ccr));
    issue(3'd3, 2'd2, d, d, 1'b0, 32'd0, {tag, " readback"});
    idle(2);
  endtask

  always @(negedge clk) begin
    if (!rst && res_vld) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R12 unexpected result", 64'(res_data), 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(res_dst == e.dst, {e.tag, " dst"}, 64'(res_dst), 64'(e.dst));
        check(res_data == e.data, {e.tag, " data"}, 64'(res_data), 64'(e.data));
        check(ccr == e.flags, {e.tag, " ccr"}, 64'(ccr), 64'(e.flags));
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 32'd0;
    m_ccr = 5'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ccr == 5'd0 && !res_vld, "R1 reset flags", 64'(ccr), 64'd0);
    for (int i = 0; i < 8; i++) issue(3'd3, 2'd2, 3'(i), 3'(i), 1'b0, 32'd0, "R1 reg cleared");
    idle(2);

    // R13 immediate loads, R6 move
    issue(3'd5, 2'd2, 3'd0, 3'd0, 1'b1, 32'hAAAA_AAFF, "R13 R6 move long");
    issue(3'd5, 2'd2, 3'd0, 3'd1, 1'b1, 32'h1234_7FFF, "R13 R6 move long");
    issue(3'd5, 2'd2, 3'd0, 3'd2, 1'b1, 32'h0000_0000, "R13 R6 move long");
    issue(3'd5, 2'd0, 3'd0, 3'd3, 1'b1, 32'h0000_0080, "R6 move byte");
    // R4 R8 byte carry into bit 8 must not happen; R7 upper kept
    issue(3'd0, 2'd0, 3'd0, 3'd0, 1'b1, 32'h0000_0001, "R4 R7 R8 byte add carry");
    // R9 word signed overflow
    issue(3'd0, 2'd1, 3'd0, 3'd1, 1'b1, 32'h0000_0001, "R4 R9 R10 word overflow");
    // R5 R8 long borrow
    issue(3'd1, 2'd2, 3'd0, 3'd2, 1'b1, 32'h0000_0001, "R5 R8 long borrow");
    // R9 byte sub overflow 0x80-1
    issue(3'd1, 2'd0, 3'd0, 3'd3, 1'b1, 32'h0000_0001, "R5 R9 byte sub overflow");
    // R11 logical keeps X, clears V C
    issue(3'd1, 2'd2, 3'd0, 3'd4, 1'b1, 32'h0000_0005, "R5 R11 set X");
    issue(3'd2, 2'd1, 3'd1, 3'd0, 1'b0, 32'd0, "R6 R11 and word");
    issue(3'd4, 2'd0, 3'd2, 3'd1, 1'b0, 32'd0, "R6 R11 xor byte");
    issue(3'd3, 2'd2, 3'd3, 3'd5, 1'b0, 32'd0, "R6 R11 or long");
    // R13 src equals dst
    issue(3'd0, 2'd2, 3'd2, 3'd2, 1'b0, 32'd0, "R13 R4 self add");
    issue(3'd1, 2'd1, 3'd1, 3'd1, 1'b0, 32'd0, "R13 R5 self sub zero");
    idle(2);

    reject(3'd0, 2'b11, 3'd1, "R2 size 11");
    reject(3'd6, 2'd2, 3'd2, "R3 op 110");
    reject(3'd7, 2'd0, 3'd3, "R3 op 111");

    // R12 inputs without strobe do nothing
    @(negedge clk);
    op_we = 1'b0; op_code = 3'd5; op_size = 2'd2; op_dst = 3'd6; op_use_imm = 1'b1; op_imm = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check(!res_vld, "R12 no strobe", 64'(res_vld), 64'd0);
    issue(3'd3, 2'd2, 3'd6, 3'd6, 1'b0, 32'd0, "R12 readback");
    idle(2);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      issue(rv[2:0], (rv[4:3] == 2'b11 && rv[5]) ? 2'd2 : rv[4:3], rv[8:6], rv[11:9], rv[12],
            $urandom, "R4 R5 R6 R7 R8 R9 R10 R11 random");
      if (rv[15:13] == 3'd0) idle(1);
    end
    idle(4);
    for (int i = 0; i < 8; i++) issue(3'd3, 2'd2, 3'(i), 3'(i), 1'b0, 32'd0, "R7 final readback");
    idle(3);
    check(sb_q.size() == 0, "R12 all results seen", 64'(sb_q.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule